// File: doc/BRIEF.md
# Card Host Register and Interrupt Front End

This block is the memory-mapped register face of a card host controller. Software reaches it through a simple single-cycle register port and finds there the power byte, the command argument, the command word, the data length and data control registers, a live data byte counter, a sticky status word with a write-one-to-clear companion, and two interrupt mask words. A 16-word window forwards accesses to the data FIFO that lives in the data engine, and a small read-only region returns eight identification words.

The command engine and the data byte engine sit outside. The block hands the command engine a one-cycle start pulse together with the decoded index, response and long-response fields and the argument. It receives status bits as set pulses, and byte-done pulses that count the data counter down. A FIFO read that removes a word raises a hold-off flag telling the data engine to defer the next refill. The flag drops when software reads either the status word or the FIFO word count, which releases the engine. Each of the two interrupt lines is registered from the status word ANDed with its own mask.

Top module: `card_host_regs`

## Requirements
- R1: After reset every register reads zero, both interrupt lines are low, the hold-off flag is low and no command start pulse is issued.
- R2: The power byte (offset 0x00) and data control (0x2C) keep only bits 7:0 of a write. The argument (0x08) keeps all 32 bits. Each mask (0x3C, 0x40) keeps the low STAT_W bits. The data length (0x28) keeps the low CNT_W bits.
- R3: The command word at 0x0C stores bits 10:0. Bits 5:0 are the command index, bit 6 requests a response and bit 7 a long response. A write with bit 10 set issues exactly one start pulse in the cycle after the write, with these fields on the command outputs. A write with bit 10 clear issues no pulse.
- R4: A data control write with bit 0 set loads the data counter (read at 0x30) from the data length. Each byte-done pulse decrements the counter, which stops at zero.
- R5: The FIFO word count at 0x48 reads (data counter + 3) >> 2.
- R6: Status (read at 0x34) ORs in set pulses each cycle. A write to 0x38 clears the status bits written as one, and a set pulse wins over a clear of the same bit in the same cycle.
- R7: Interrupt line i goes high one cycle after (status AND mask i) becomes nonzero and goes low one cycle after it becomes zero. Mask 0 drives line 0 and mask 1 drives line 1.
- R8: A read anywhere in 0x80 to 0xBC pops one word and returns it when the FIFO is not empty, and then sets the hold-off flag. When the FIFO is empty such a read returns zero, pops nothing and leaves the flag unchanged.
- R9: A write anywhere in 0x80 to 0xBC pushes the written word when the data counter is nonzero and is ignored when it is zero.
- R10: A read of status (0x34) or of the FIFO word count (0x48) clears the hold-off flag. Other reads leave the flag as it is.
- R11: Reads at 0xFE0 to 0xFFC return identification word k = address bits 4:2, whose value is byte k of the ID_BYTES parameter, zero-extended.
- R12: Unmapped offsets read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on the access cycle |
| cmd_start | output | 1 | One-cycle command start pulse |
| cmd_index | output | 6 | Command index field |
| cmd_resp | output | 1 | Response requested |
| cmd_long | output | 1 | Long response requested |
| cmd_arg | output | 32 | Command argument |
| data_ctrl | output | 8 | Data control byte |
| pwr_ctrl | output | 8 | Power byte |
| stat_set | input | STAT_W | Status set pulses from the engines |
| byte_done | input | 1 | One data byte moved; decrements the counter |
| fifo_empty | input | 1 | Data FIFO is empty |
| fifo_rdata | input | 32 | Word at the head of the data FIFO |
| fifo_pop | output | 1 | Pop strobe, on the access cycle |
| fifo_push | output | 1 | Push strobe, on the access cycle |
| fifo_wdata | output | 32 | Word to push |
| data_hold | output | 1 | Hold-off flag to the data engine |
| irq | output | 2 | Masked interrupt lines |

## Verification
A wrong status or mask value appears on the interrupt lines exactly one clock after the bad value forms. A corrupted data counter shows at once in reads of both the counter and the word count, and it also changes whether FIFO writes are pushed. A hold-off flag that is stuck or cleared at the wrong time shows on data_hold in the cycle after the offending access, so the bench samples it right after single reads of the status, count and counter offsets.

// File: rtl/card_host_regs.sv
module card_host_regs #(
  parameter int ADDR_W = 12,
  parameter int CNT_W = 16,
  parameter int STAT_W = 24,
  parameter logic [63:0] ID_BYTES = 64'h0D_F0_05_B1_2A_1E_14_00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              cmd_start,
  output logic [5:0]        cmd_index,
  output logic              cmd_resp,
  output logic              cmd_long,
  output logic [31:0]       cmd_arg,
  output logic [7:0]        data_ctrl,
  output logic [7:0]        pwr_ctrl,
  input  logic [STAT_W-1:0] stat_set,
  input  logic              byte_done,
  input  logic              fifo_empty,
  input  logic [31:0]       fifo_rdata,
  output logic              fifo_pop,
  output logic              fifo_push,
  output logic [31:0]       fifo_wdata,
  output logic              data_hold,
  output logic [1:0]        irq
);
  localparam int WCNT_W = CNT_W - 1;

  logic [10:0]       cmd_q;
  logic [CNT_W-1:0]  len_q, cnt_q;
  logic [STAT_W-1:0] stat_q, mask0_q, mask1_q;
  logic [CNT_W:0]    words;

  wire wr_en = bus_sel & bus_wr;
  wire rd_en = bus_sel & ~bus_wr;
  wire in_fifo = bus_addr[ADDR_W-1:6] == (ADDR_W-6)'(2);
  wire in_id = bus_addr[ADDR_W-1:5] == {(ADDR_W-5){1'b1}};
  wire hit_stat = bus_addr == ADDR_W'('h34);
  wire hit_wcnt = bus_addr == ADDR_W'('h48);
  wire hit_dctl = bus_addr == ADDR_W'('h2C);
  wire hit_clr = bus_addr == ADDR_W'('h38);

  assign words = ({1'b0, cnt_q} + (CNT_W+1)'(3)) >> 2;
  assign fifo_pop = rd_en & in_fifo & ~fifo_empty;
  assign fifo_push = wr_en & in_fifo & (cnt_q != '0);
  assign fifo_wdata = bus_wdata;
  assign cmd_index = cmd_q[5:0];
  assign cmd_resp = cmd_q[6];
  assign cmd_long = cmd_q[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_ctrl <= '0;
      cmd_arg <= '0;
      cmd_q <= '0;
      len_q <= '0;
      data_ctrl <= '0;
      mask0_q <= '0;
      mask1_q <= '0;
      cmd_start <= 1'b0;
    end else begin
      cmd_start <= 1'b0;
      if (wr_en) begin
        case (bus_addr)
          ADDR_W'('h00): pwr_ctrl <= bus_wdata[7:0];
          ADDR_W'('h08): cmd_arg <= bus_wdata;
          ADDR_W'('h0C): begin
            cmd_q <= bus_wdata[10:0];
            cmd_start <= bus_wdata[10];
          end
          ADDR_W'('h28): len_q <= bus_wdata[CNT_W-1:0];
          ADDR_W'('h2C): data_ctrl <= bus_wdata[7:0];
          ADDR_W'('h3C): mask0_q <= bus_wdata[STAT_W-1:0];
          ADDR_W'('h40): mask1_q <= bus_wdata[STAT_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      stat_q <= '0;
      data_hold <= 1'b0;
      irq <= '0;
    end else begin
      if (wr_en && hit_dctl && bus_wdata[0]) cnt_q <= len_q;
      else if (byte_done && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      if (wr_en && hit_clr) stat_q <= (stat_q & ~bus_wdata[STAT_W-1:0]) | stat_set;
      else stat_q <= stat_q | stat_set;
      if (fifo_pop) data_hold <= 1'b1;
      else if (rd_en && (hit_stat || hit_wcnt)) data_hold <= 1'b0;
      irq <= {|(stat_q & mask1_q), |(stat_q & mask0_q)};
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (in_fifo) bus_rdata = fifo_empty ? 32'd0 : fifo_rdata;
    else if (in_id) bus_rdata = 32'(ID_BYTES[8*bus_addr[4:2] +: 8]);
    else begin
      case (bus_addr)
        ADDR_W'('h00): bus_rdata = 32'(pwr_ctrl);
        ADDR_W'('h08): bus_rdata = cmd_arg;
        ADDR_W'('h0C): bus_rdata = 32'(cmd_q);
        ADDR_W'('h28): bus_rdata = 32'(len_q);
        ADDR_W'('h2C): bus_rdata = 32'(data_ctrl);
        ADDR_W'('h30): bus_rdata = 32'(cnt_q);
        ADDR_W'('h34): bus_rdata = 32'(stat_q);
        ADDR_W'('h3C): bus_rdata = 32'(mask0_q);
        ADDR_W'('h40): bus_rdata = 32'(mask1_q);
        ADDR_W'('h48): bus_rdata = 32'(words[WCNT_W:0]);
        default: bus_rdata = '0;
      endcase
    end
  end

  a_r7_irq0_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat_q & mask0_q)) |=> irq[0]);
  a_r7_irq1_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(stat_q & mask1_q)) |=> !irq[1]);
  a_r8_pop_sets_hold: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |=> data_hold);
  a_r8_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_empty |-> !fifo_pop);
  a_r9_no_push_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) |-> !fifo_push);
  a_r10_stat_read_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && hit_stat) |=> !data_hold);
  a_r4_count_never_rises: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && hit_dctl && bus_wdata[0]) |=> cnt_q <= $past(cnt_q));
  a_r6_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && hit_clr) |=> (stat_q & $past(stat_q)) == $past(stat_q));
  a_r3_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> !cmd_start);
endmodule

// File: tb/card_host_regs_tb.sv
module card_host_regs_tb;
  localparam logic [63:0] IDB = 64'h0D_F0_05_B1_2A_1E_14_00;
  localparam logic [31:0] FDATA = 32'hC0FFEE11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 0, bus_wr = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, cmd_arg, fifo_wdata;
  logic cmd_start, cmd_resp, cmd_long, fifo_pop, fifo_push, data_hold;
  logic [5:0] cmd_index;
  logic [7:0] data_ctrl, pwr_ctrl;
  logic [23:0] stat_set = '0;
  logic byte_done = 0, fifo_empty = 1;
  logic [1:0] irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  card_host_regs u_dut (.clk, .rst_n, .bus_sel, .bus_wr, .bus_addr, .bus_wdata,
    .bus_rdata, .cmd_start, .cmd_index, .cmd_resp, .cmd_long, .cmd_arg,
    .data_ctrl, .pwr_ctrl, .stat_set, .byte_done, .fifo_empty,
    .fifo_rdata(FDATA), .fifo_pop, .fifo_push, .fifo_wdata, .data_hold, .irq);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  logic [31:0] rd;
  logic pu, po;
  task automatic acc(bit w, logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = w; bus_addr = a; bus_wdata = d;
    #1 rd = bus_rdata; pu = fifo_push; po = fifo_pop;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  localparam int NV = 14;
  localparam logic [76:0] VEC [NV] = '{
    {1'b1, 12'h000, 32'hABCD1234, 32'h0}, {1'b0, 12'h000, 32'h0, 32'h34},
    {1'b1, 12'h008, 32'hDEADBEEF, 32'h0}, {1'b0, 12'h008, 32'h0, 32'hDEADBEEF},
    {1'b1, 12'h03C, 32'hFFFFFFFF, 32'h0}, {1'b0, 12'h03C, 32'h0, 32'h00FFFFFF},
    {1'b1, 12'h028, 32'hFFFF0005, 32'h0}, {1'b0, 12'h028, 32'h0, 32'h5},
    {1'b1, 12'h02C, 32'h000001F2, 32'h0}, {1'b0, 12'h02C, 32'h0, 32'hF2},
    {1'b1, 12'h010, 32'h12345678, 32'h0}, {1'b0, 12'h010, 32'h0, 32'h0},
    {1'b0, 12'hFE0, 32'h0, 32'h0}, {1'b0, 12'hFFC, 32'h0, 32'h0D}
  };

  initial begin
    #(8*100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    acc(0, 12'h034, 0); chk("R1 status", rd, 0);
    acc(0, 12'h030, 0); chk("R1 count", rd, 0);
    chk("R1 irq", 32'(irq), 0); chk("R1 hold", 32'(data_hold), 0);
    chk("R1 start", 32'(cmd_start), 0);
    // R2 R11 R12 vector table
    for (int i = 0; i < NV; i++) begin
      acc(VEC[i][76], VEC[i][75:64], VEC[i][63:32]);
      if (!VEC[i][76]) chk("R2/R11/R12 vector", rd, VEC[i][31:0]);
    end
    chk("R2 power out", 32'(pwr_ctrl), 32'h34);
    acc(0, 12'hFE4, 0); chk("R11 id word1", rd, 32'(IDB[15:8]));
    acc(0, 12'h030, 0); chk("R12 no side write to count", rd, 0);
    acc(1, 12'h03C, 0);
    // R3 command
    acc(1, 12'h008, 32'h11223344);
    acc(1, 12'h00C, 32'h4C5);
    chk("R3 start pulse", 32'(cmd_start), 1);
    chk("R3 fields", {cmd_long, cmd_resp, cmd_index, cmd_arg[7:0]}, {1'b1, 1'b1, 6'd5, 8'h44});
    @(negedge clk); chk("R3 single pulse", 32'(cmd_start), 0);
    acc(1, 12'h00C, 32'h0C5); chk("R3 no start bit", 32'(cmd_start), 0);
    acc(0, 12'h00C, 0); chk("R3 readback", rd, 32'h0C5);
    // R4 R5 counter
    acc(1, 12'h028, 6); acc(1, 12'h02C, 1);
    acc(0, 12'h030, 0); chk("R4 load", rd, 6);
    acc(0, 12'h048, 0); chk("R5 words of 6", rd, 2);
    @(negedge clk); byte_done = 1; repeat (5) @(negedge clk); byte_done = 0;
    acc(0, 12'h048, 0); chk("R5 words of 1", rd, 1);
    @(negedge clk); byte_done = 1; repeat (3) @(negedge clk); byte_done = 0;
    acc(0, 12'h030, 0); chk("R4 stops at zero", rd, 0);
    // R9 FIFO writes
    acc(1, 12'h080, 32'hAAAA5555); chk("R9 ignored at zero count", 32'(pu), 0);
    acc(1, 12'h02C, 1);
    acc(1, 12'h09C, 32'h13579BDF); chk("R9 push", 32'(pu), 1);
    chk("R9 push data", fifo_wdata, 32'h13579BDF);
    // R8 R10 FIFO reads and hold-off
    fifo_empty = 1;
    acc(0, 12'h084, 0); chk("R8 empty reads zero", rd, 0);
    chk("R8 empty no pop", 32'(po), 0); chk("R8 empty no hold", 32'(data_hold), 0);
    fifo_empty = 0;
    acc(0, 12'h0BC, 0); chk("R8 pop data", rd, FDATA); chk("R8 pop", 32'(po), 1);
    chk("R8 hold set", 32'(data_hold), 1);
    acc(0, 12'h030, 0); chk("R10 other read keeps hold", 32'(data_hold), 1);
    acc(0, 12'h034, 0); chk("R10 status read clears", 32'(data_hold), 0);
    acc(0, 12'h0A0, 0); chk("R8 hold again", 32'(data_hold), 1);
    acc(0, 12'h048, 0); chk("R10 count read clears", 32'(data_hold), 0);
    fifo_empty = 1;
    // R6 R7 status and interrupts
    acc(1, 12'h03C, 32'h4); acc(1, 12'h040, 32'h2);
    @(negedge clk); stat_set = 24'h6;
    @(negedge clk); stat_set = 0;
    chk("R7 irq lags status", 32'(irq), 0);
    @(negedge clk); chk("R7 both lines", 32'(irq), 3);
    acc(0, 12'h034, 0); chk("R6 sticky set", rd, 6);
    acc(1, 12'h038, 32'h4); chk("R7 irq still old", 32'(irq), 3);
    @(negedge clk); chk("R7 line0 drops", 32'(irq), 2);
    acc(0, 12'h034, 0); chk("R6 clear", rd, 2);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 12'h038; bus_wdata = 32'h1; stat_set = 24'h1;
    @(negedge clk); bus_sel = 0; bus_wr = 0; stat_set = 0;
    acc(0, 12'h034, 0); chk("R6 set wins", rd, 3);
    // R1 mid-test reset
    @(negedge clk); rst_n = 0; @(negedge clk);
    chk("R1 irq in reset", 32'(irq), 0);
    rst_n = 1;
    acc(0, 12'h000, 0); chk("R1 power cleared", rd, 0);
    acc(0, 12'h040, 0); chk("R1 mask cleared", rd, 0);
    acc(0, 12'h034, 0); chk("R1 status cleared", rd, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule